// File: doc/BRIEF.md
# E1 Spare-Bit Multiframe Capture

This block watches the receive side of an E1 link that runs in CRC-4 multiframe mode. It picks out the national spare bits carried in time slot 0, at bit positions 4 to 8 of the word that alternates with the frame alignment word. Each position is sent once in every odd frame of the 16-frame multiframe, so each position gives eight samples per multiframe. The block keeps those samples as one 8-bit value per position.

An upstream framer supplies the received bit together with its position: a bit-in-slot index, a slot index and a frame-in-multiframe number. It also supplies a strobe at the start of each multiframe. The samples go into a shadow store while the multiframe is received. On the multiframe-begin strobe, all five values are copied to the output register in one step, and a one-cycle pulse reports the update to an interrupt source. When the link is not in CRC-4 multiframe mode, nothing is captured and the outputs keep their last values.

Top module: `e1_spare_capture`

## Requirements
- R1: While `rst` is high and in the cycle after it, `spare_q` reads all zeros and `upd_pulse` is low.
- R2: A bit is sampled only when all of these hold: `rx_valid` is 1, `crc_mf_en` is 1, `ts_idx` is 0, `frm_idx` is odd, and `bit_idx` is 3 to 7. Here `bit_idx` 0 is the first bit of the slot (position 1) and 7 is position 8. Bits in even frames, in other slots, at positions 1 to 3, or with `rx_valid` low have no effect on any output value.
- R3: Position 4+k (k = 0 to 4) is published in `spare_q[8k+7:8k]`. Within that byte, the sample from frame 2j+1 lands in bit j, so frame 1 goes to bit 0 and frame 15 goes to bit 7.
- R4: `spare_q` changes only on the clock edge that samples `mf_begin` high with `crc_mf_en` high. It then shows every sample of the multiframe just finished, all five bytes together.
- R5: While `crc_mf_en` is low, no samples are stored, `mf_begin` does not update `spare_q`, and `spare_q` holds its value.
- R6: `upd_pulse` is high for exactly the one cycle after an edge that samples `mf_begin` and `crc_mf_en` both high, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crc_mf_en | input | 1 | CRC-4 multiframe mode enabled |
| rx_valid | input | 1 | `rx_bit` and its indices are valid this cycle |
| rx_bit | input | 1 | Received serial data bit |
| bit_idx | input | 3 | Bit position within slot, 0 = first bit |
| ts_idx | input | 5 | Time slot number, 0 to 31 |
| frm_idx | input | 4 | Frame number within multiframe, 0 to 15 |
| mf_begin | input | 1 | Multiframe start strobe |
| spare_q | output | 40 | Published spare bits, five bytes |
| upd_pulse | output | 1 | One-cycle pulse after each publish |

## Verification
The hardest case to reach from the ports is a multiframe whose samples must not count. The CRC-4 mode is dropped for a whole multiframe, including its start strobe, with a new pattern on the line. After the mode comes back, the next publish must show the multiframe from before the gap and nothing from inside it. The stimulus therefore sends enabled, disabled and enabled multiframes in sequence, and checks the held outputs during the gap. In every multiframe it also fills the even frames, the other slots and positions 1 to 3 with the complement of the spare pattern, and adds idle cycles with the data bit inverted. Any wrongly sampled bit therefore shows up as a flipped bit in a published byte.

// File: rtl/e1sa_pkg.sv
package e1sa_pkg;
  localparam int unsigned DEF_LANES     = 5;
  localparam int unsigned DEF_FIRST_POS = 4;
  localparam int unsigned DEF_FRAMES    = 16;
  localparam int unsigned DEF_TS_W      = 5;
  localparam int unsigned DEF_BIT_W     = 3;

  function automatic int unsigned slots_of(input int unsigned frames);
    return frames / 2;
  endfunction
endpackage

// File: rtl/e1sa_decode.sv
module e1sa_decode #(
  parameter int unsigned LANES     = e1sa_pkg::DEF_LANES,
  parameter int unsigned FIRST_POS = e1sa_pkg::DEF_FIRST_POS,
  parameter int unsigned TS_W      = e1sa_pkg::DEF_TS_W,
  parameter int unsigned BIT_W     = e1sa_pkg::DEF_BIT_W,
  parameter int unsigned FRM_W     = 4,
  parameter int unsigned LANE_W    = 3,
  parameter int unsigned SLOT_W    = 3
) (
  input  logic              rx_valid,
  input  logic              crc_mf_en,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic [TS_W-1:0]   ts_idx,
  input  logic [FRM_W-1:0]  frm_idx,
  output logic              hit,
  output logic [LANE_W-1:0] lane,
  output logic [SLOT_W-1:0] slot
);
  localparam int LO = int'(FIRST_POS) - 1;
  localparam int HI = LO + int'(LANES);

  logic [BIT_W-1:0] offs;
  logic             in_range;

  always_comb begin
    offs     = bit_idx - BIT_W'(LO);
    in_range = (int'(bit_idx) >= LO) && (int'(bit_idx) < HI);
    hit      = rx_valid && crc_mf_en && (ts_idx == '0) && frm_idx[0] && in_range;
    lane     = offs[LANE_W-1:0];
    slot     = frm_idx[FRM_W-1:1];
  end
endmodule

// File: rtl/e1sa_shadow.sv
module e1sa_shadow #(
  parameter int unsigned LANES  = e1sa_pkg::DEF_LANES,
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned LANE_W = 3,
  parameter int unsigned SLOT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hit,
  input  logic [LANE_W-1:0]      lane,
  input  logic [SLOT_W-1:0]      slot,
  input  logic                   rx_bit,
  output logic [LANES*SLOTS-1:0] shadow
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SLOTS-1:0] acc;
    always_ff @(posedge clk) begin
      if (rst) begin
        acc <= '0;
      end else if (hit && (lane == LANE_W'(g))) begin
        acc[slot] <= rx_bit;
      end
    end
    assign shadow[g*SLOTS +: SLOTS] = acc;
  end
endmodule

// File: rtl/e1sa_publish.sv
module e1sa_publish #(
  parameter int unsigned W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mf_begin,
  input  logic         crc_mf_en,
  input  logic [W-1:0] shadow,
  output logic [W-1:0] spare_q,
  output logic         upd_pulse
);
  logic take;
  assign take = mf_begin && crc_mf_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      spare_q   <= '0;
      upd_pulse <= 1'b0;
    end else begin
      upd_pulse <= take;
      if (take) spare_q <= shadow;
    end
  end
endmodule

// File: rtl/e1_spare_capture.sv
module e1_spare_capture #(
  parameter int unsigned LANES     = e1sa_pkg::DEF_LANES,
  parameter int unsigned FIRST_POS = e1sa_pkg::DEF_FIRST_POS,
  parameter int unsigned FRAMES    = e1sa_pkg::DEF_FRAMES,
  parameter int unsigned TS_W      = e1sa_pkg::DEF_TS_W,
  parameter int unsigned BIT_W     = e1sa_pkg::DEF_BIT_W,
  localparam int unsigned SLOTS    = e1sa_pkg::slots_of(FRAMES),
  localparam int unsigned FRM_W    = $clog2(FRAMES),
  localparam int unsigned W        = LANES * SLOTS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             crc_mf_en,
  input  logic             rx_valid,
  input  logic             rx_bit,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic [TS_W-1:0]  ts_idx,
  input  logic [FRM_W-1:0] frm_idx,
  input  logic             mf_begin,
  output logic [W-1:0]     spare_q,
  output logic             upd_pulse
);
  localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic              hit;
  logic [LANE_W-1:0] lane;
  logic [SLOT_W-1:0] slot;
  logic [W-1:0]      shadow;

  e1sa_decode #(
    .LANES(LANES), .FIRST_POS(FIRST_POS), .TS_W(TS_W), .BIT_W(BIT_W),
    .FRM_W(FRM_W), .LANE_W(LANE_W), .SLOT_W(SLOT_W)
  ) u_decode (
    .rx_valid(rx_valid), .crc_mf_en(crc_mf_en), .bit_idx(bit_idx),
    .ts_idx(ts_idx), .frm_idx(frm_idx), .hit(hit), .lane(lane), .slot(slot)
  );

  e1sa_shadow #(
    .LANES(LANES), .SLOTS(SLOTS), .LANE_W(LANE_W), .SLOT_W(SLOT_W)
  ) u_shadow (
    .clk(clk), .rst(rst), .hit(hit), .lane(lane), .slot(slot),
    .rx_bit(rx_bit), .shadow(shadow)
  );

  e1sa_publish #(.W(W)) u_publish (
    .clk(clk), .rst(rst), .mf_begin(mf_begin), .crc_mf_en(crc_mf_en),
    .shadow(shadow), .spare_q(spare_q), .upd_pulse(upd_pulse)
  );
endmodule

// File: rtl/e1sa_chk.sv
module e1sa_chk #(
  parameter int unsigned W = 40
) (
  input logic         clk,
  input logic         rst,
  input logic         crc_mf_en,
  input logic         mf_begin,
  input logic [W-1:0] spare_q,
  input logic         upd_pulse
);
  AST_HOLD_NO_BEGIN: assert property (@(posedge clk) disable iff (rst)
    !mf_begin |=> $stable(spare_q)); // R4
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !crc_mf_en |=> $stable(spare_q)); // R5
  AST_PULSE_AFTER_BEGIN: assert property (@(posedge clk) disable iff (rst)
    (mf_begin && crc_mf_en) |=> upd_pulse); // R6
  AST_PULSE_ONLY_AFTER_BEGIN: assert property (@(posedge clk) disable iff (rst)
    !(mf_begin && crc_mf_en) |=> !upd_pulse); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (spare_q == '0) && !upd_pulse); // R1
endmodule

bind e1_spare_capture e1sa_chk #(.W(W)) u_e1sa_chk (
  .clk(clk), .rst(rst), .crc_mf_en(crc_mf_en), .mf_begin(mf_begin),
  .spare_q(spare_q), .upd_pulse(upd_pulse)
);

// File: tb/test_e1_spare_capture.sv
module test_e1_spare_capture;
  localparam int CLK_PERIOD = 10;
  localparam int W = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic crc_mf_en = 1'b0, rx_valid = 1'b0, rx_bit = 1'b0, mf_begin = 1'b0;
  logic [2:0] bit_idx = '0;
  logic [4:0] ts_idx = '0;
  logic [3:0] frm_idx = '0;
  logic [W-1:0] spare_q;
  logic upd_pulse;

  int checks = 0, errors = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] model_sh = '0;
  logic [W-1:0] last_pub = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_spare_capture i_e1_spare_capture (
    .clk(clk), .rst(rst), .crc_mf_en(crc_mf_en), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .bit_idx(bit_idx), .ts_idx(ts_idx), .frm_idx(frm_idx),
    .mf_begin(mf_begin), .spare_q(spare_q), .upd_pulse(upd_pulse)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops an expected publish for every update pulse
  always @(negedge clk) begin
    if (!rst && upd_pulse) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 pulse without enabled begin", spare_q, '0);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        for (int k = 0; k < 5; k++)
          check(spare_q[8*k +: 8] == e[8*k +: 8], $sformatf("R3 R4 lane %0d", k),
                W'(spare_q[8*k +: 8]), W'(e[8*k +: 8]));
      end
    end
  end

  task automatic drive(input logic b, input int bi, input int ts, input int fr,
                       input logic mfb, input logic vld);
    @(negedge clk);
    rx_bit = b; bit_idx = 3'(bi); ts_idx = 5'(ts); frm_idx = 4'(fr);
    mf_begin = mfb; rx_valid = vld;
  endtask

  // one multiframe; spare positions carry pat, every other bit carries a complement
  task automatic send_mf(input logic [W-1:0] pat, input bit gaps);
    for (int fr = 0; fr < 16; fr++)
      for (int ts = 0; ts < 32; ts++)
        for (int bi = 0; bi < 8; bi++) begin
          logic mfb, b;
          mfb = (fr == 0 && ts == 0 && bi == 0);
          if (mfb && crc_mf_en) begin
            exp_q.push_back(model_sh);
            last_pub = model_sh;
          end
          if (ts == 0 && fr % 2 == 1 && bi >= 3) b = pat[(bi-3)*8 + fr/2];
          else b = ~pat[(bi % 5)*8 + fr/2];
          drive(b, bi, ts, fr, mfb, 1'b1);
          if (gaps && ts == 0 && bi >= 2) drive(~b, bi, ts, fr, 1'b0, 1'b0); // R2 idle cycle
        end
    if (crc_mf_en) model_sh = pat;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(spare_q == '0 && !upd_pulse, "R1 reset state", spare_q, '0);
    rst = 1'b0;
    @(negedge clk);
    check(spare_q == '0 && !upd_pulse, "R1 after reset", spare_q, '0);
    crc_mf_en = 1'b1;
    send_mf(40'hA5_3C_0F_81_7E, 1'b0);  // first begin publishes zeros
    send_mf(40'h12_FF_00_C3_69, 1'b1);  // R2 idle gaps
    crc_mf_en = 1'b0;
    send_mf(40'h5A_E7_18_3C_96, 1'b0);  // R5 disabled multiframe
    @(negedge clk);
    check(spare_q == last_pub, "R5 hold while disabled", spare_q, last_pub);
    check(exp_q.size() == 0, "R5 R6 no pulse while disabled", W'(exp_q.size()), '0);
    crc_mf_en = 1'b1;
    send_mf(40'h01_80_55_AA_F0, 1'b0);  // publishes the pre-gap multiframe
    send_mf(40'hDE_AD_BE_EF_42, 1'b1);
    drive(1'b0, 0, 0, 0, 1'b1, 1'b1);   // final begin
    exp_q.push_back(model_sh);
    drive(1'b0, 0, 0, 0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R6 every begin gave a pulse", W'(exp_q.size()), '0);
    check(spare_q == 40'hDE_AD_BE_EF_42, "R4 final publish", spare_q, 40'hDE_AD_BE_EF_42);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule